// File: doc/BRIEF.md
# Parallel TLB and Cache Lookup

This block is the data-side load lookup of a 32-bit machine. On a read request it probes a four-entry fully associative translation buffer and a two-way set-associative data cache at the same clock edge. The cache set is chosen from address bits that lie inside the 16 KB page, so they are the same before and after translation. Each cache way then compares its stored tag with the physical page number produced by the translation buffer in that same cycle.

One cycle after a request the block presents four results: the physical address, the selected 32-bit word, a translation hit flag and a cache hit flag. A miss is only reported through the flags, and the caller refills through two simple write ports. One port loads translation entries in round-robin order. The other loads whole 32-byte lines. A line goes into an empty way if the set has one, and otherwise replaces the least recently used way.

Top module: `xlat_cache_lookup`

## Requirements
- R1: After reset every translation entry and every cache line is invalid, and the outputs `rd_pa`, `tlb_hit` and `cache_hit` are 0. A read before any fill reports no translation hit. A read after translation fills but before line fills reports a translation hit and no cache hit.
- R2: A request with `rd_va[31:14]` equal to the virtual page number of a valid translation entry gives `tlb_hit`=1 one cycle later. In that cycle `rd_pa` = {stored physical page number, `rd_va[13:0]`}.
- R3: A request whose virtual page number matches no valid entry gives `tlb_hit`=0, `cache_hit`=0 and `rd_pa`=0 one cycle later.
- R4: `cache_hit`=1 when a valid way of set `rd_va[13:5]` holds a tag equal to the translated physical page number. `rd_data` is then word `rd_va[4:2]` of that line, where word k occupies bits [32k+31:32k] of the filled line.
- R5: `cache_hit` is never 1 without `tlb_hit`, even when the set holds a line whose tag equals some other page.
- R6: A line fill writes way 0 if way 0 of the set is invalid, otherwise way 1 if way 1 is invalid, and marks the written way valid.
- R7: When both ways of a set are valid, a line fill replaces the least recently used way. Both a read hit and a fill make the touched way the most recent.
- R8: Translation fills go to entries 0, 1, 2, 3 in turn, starting at entry 0 after reset. The fifth fill overwrites entry 0.
- R9: A cycle with `rd_req`=0 gives `tlb_hit`=0 and `cache_hit`=0 in the following cycle.
- R10: The set is chosen from `rd_va[13:5]` only, so two virtual pages that map to the same physical page hit the same cached line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read lookup request |
| rd_va | input | 32 | Virtual byte address of the read |
| rd_pa | output | 32 | Translated physical address (0 on translation miss) |
| rd_data | output | 32 | Selected word (0 on cache miss) |
| tlb_hit | output | 1 | Translation hit for the previous cycle's request |
| cache_hit | output | 1 | Cache hit for the previous cycle's request |
| tlb_fill_en | input | 1 | Write one translation entry |
| tlb_fill_vpn | input | 18 | Virtual page number to store |
| tlb_fill_ppn | input | 18 | Physical page number to store |
| line_fill_en | input | 1 | Write one cache line |
| line_fill_tag | input | 18 | Physical page number of the line |
| line_fill_set | input | 9 | Set index of the line |
| line_fill_data | input | 256 | Line contents, word 0 in the low bits |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16 KB pages, a 32 KB cache of 32-byte lines and four translation entries, which yields 512 sets of two ways. These values bring the top set 511, an all-ones virtual and physical page number, and a translation-buffer wrap at the fifth fill within reach of a short run. With two ways per set, one extra fill into a set that is already full exercises the recency replacement. An alias entry that maps two virtual pages onto one physical page shows that only page-offset bits choose the set.

// File: rtl/lk_pkg.sv
package lk_pkg;

    localparam int LK_ADDR_W     = 32;
    localparam int LK_PAGE_BITS  = 14;
    localparam int LK_LINE_BYTES = 32;
    localparam int LK_CACHE_BYTES = 32768;
    localparam int LK_TLB_N      = 4;
    localparam int LK_WORD_W     = 32;

    // Victim choice for a two-way set: first empty way, else the recency bit.
    function automatic logic pick_way(input logic [1:0] valid, input logic lru);
        if (!valid[0])      return 1'b0;
        else if (!valid[1]) return 1'b1;
        else                return lru;
    endfunction

endpackage

// File: rtl/lk_tlb.sv
module lk_tlb #(
    parameter int ENTRIES = lk_pkg::LK_TLB_N,
    parameter int VPN_W   = 18,
    parameter int PPN_W   = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             look_hit,
    output logic [PPN_W-1:0] look_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [PTR_W-1:0]              ptr;
    } tlb_st_t;

    tlb_st_t st_d, st_q;
    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0]   enc_idx;

    // One comparator per entry
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = st_q.valid[i] && (st_q.vpn[i] == look_vpn);
    end

    always_comb begin
        // one-hot to binary encoder
        enc_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) enc_idx = enc_idx | PTR_W'(i);
        end
        look_hit = |match;
        look_ppn = look_hit ? st_q.ppn[enc_idx] : '0;

        st_d = st_q;
        if (fill_en) begin
            st_d.valid[st_q.ptr] = 1'b1;
            st_d.vpn[st_q.ptr]   = fill_vpn;
            st_d.ppn[st_q.ptr]   = fill_ppn;
            st_d.ptr = (st_q.ptr == PTR_W'(ENTRIES - 1)) ? '0 : PTR_W'(st_q.ptr + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    assert_rr_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (st_q.ptr == (($past(st_q.ptr) == PTR_W'(ENTRIES - 1)) ? '0
                                  : PTR_W'($past(st_q.ptr) + 1'b1))));

endmodule

// File: rtl/lk_cache.sv
module lk_cache #(
    parameter int SETS   = 512,
    parameter int TAG_W  = 18,
    parameter int WORDS  = 8,
    parameter int WORD_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [$clog2(SETS)-1:0]      rd_set,
    input  logic [$clog2(WORDS)-1:0]     rd_word,
    input  logic [TAG_W-1:0]             rd_tag,
    input  logic                         rd_tag_ok,
    output logic                         rd_hit,
    output logic [WORD_W-1:0]            rd_data,
    input  logic                         fill_en,
    input  logic [$clog2(SETS)-1:0]      fill_set,
    input  logic [TAG_W-1:0]             fill_tag,
    input  logic [WORDS-1:0][WORD_W-1:0] fill_line
);
    localparam int WAYS  = 2;
    localparam int SET_W = $clog2(SETS);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0] valid;
        logic [SETS-1:0]           lru;   // way to evict next
    } ca_st_t;

    ca_st_t st_d, st_q;
    logic [WAYS-1:0]             way_hit;
    logic [WAYS-1:0][WORD_W-1:0] way_word;
    logic                        fill_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0]             tag_mem  [SETS];
        logic [WORDS-1:0][WORD_W-1:0] line_mem [SETS];

        assign way_hit[w]  = rd_tag_ok && st_q.valid[rd_set][w] && (tag_mem[rd_set] == rd_tag);
        assign way_word[w] = line_mem[rd_set][rd_word];

        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == 1'(w))) begin
                tag_mem[fill_set]  <= fill_tag;
                line_mem[fill_set] <= fill_line;
            end
        end
    end

    always_comb begin
        rd_hit   = |way_hit;
        rd_data  = way_hit[1] ? way_word[1] : (way_hit[0] ? way_word[0] : '0);
        fill_way = lk_pkg::pick_way(st_q.valid[fill_set], st_q.lru[fill_set]);

        st_d = st_q;
        if (rd_en && rd_hit) st_d.lru[rd_set] = way_hit[0];
        if (fill_en) begin
            st_d.valid[fill_set][fill_way] = 1'b1;
            st_d.lru[fill_set]             = ~fill_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_way_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    assert_fill_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> st_q.valid[$past(fill_set)][$past(fill_way)]);

    assert_lru_after_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_hit && !fill_en) |=> (st_q.lru[$past(rd_set)] == $past(way_hit[0])));

endmodule

// File: rtl/xlat_cache_lookup.sv
module xlat_cache_lookup #(
    parameter int ADDR_W      = lk_pkg::LK_ADDR_W,
    parameter int PAGE_BITS   = lk_pkg::LK_PAGE_BITS,
    parameter int LINE_BYTES  = lk_pkg::LK_LINE_BYTES,
    parameter int CACHE_BYTES = lk_pkg::LK_CACHE_BYTES,
    parameter int TLB_ENTRIES = lk_pkg::LK_TLB_N,
    parameter int WORD_W      = lk_pkg::LK_WORD_W,
    localparam int VPN_W      = ADDR_W - PAGE_BITS,
    localparam int LINE_BITS  = $clog2(LINE_BYTES),
    localparam int SETS       = CACHE_BYTES / (LINE_BYTES * 2),
    localparam int SET_W      = $clog2(SETS),
    localparam int WB_BITS    = $clog2(WORD_W / 8),
    localparam int WORDS      = LINE_BYTES / (WORD_W / 8),
    localparam int LINE_W     = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_va,
    output logic [ADDR_W-1:0] rd_pa,
    output logic [WORD_W-1:0] rd_data,
    output logic              tlb_hit,
    output logic              cache_hit,
    input  logic              tlb_fill_en,
    input  logic [VPN_W-1:0]  tlb_fill_vpn,
    input  logic [VPN_W-1:0]  tlb_fill_ppn,
    input  logic              line_fill_en,
    input  logic [VPN_W-1:0]  line_fill_tag,
    input  logic [SET_W-1:0]  line_fill_set,
    input  logic [LINE_W-1:0] line_fill_data
);
    typedef struct packed {
        logic [ADDR_W-1:0] pa;
        logic [WORD_W-1:0] data;
        logic              xl_hit;
        logic              ca_hit;
    } resp_t;

    resp_t resp_d, resp_q;

    logic             xl_hit_w;
    logic [VPN_W-1:0] xl_ppn_w;
    logic             ca_hit_w;
    logic [WORD_W-1:0] ca_word_w;

    lk_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PPN_W(VPN_W)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_vpn (rd_va[ADDR_W-1:PAGE_BITS]),
        .look_hit (xl_hit_w),
        .look_ppn (xl_ppn_w),
        .fill_en  (tlb_fill_en),
        .fill_vpn (tlb_fill_vpn),
        .fill_ppn (tlb_fill_ppn)
    );

    // Set and word come from page-offset bits only, so this runs beside the TLB.
    lk_cache #(.SETS(SETS), .TAG_W(VPN_W), .WORDS(WORDS), .WORD_W(WORD_W)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_req),
        .rd_set    (rd_va[LINE_BITS +: SET_W]),
        .rd_word   (rd_va[WB_BITS +: $clog2(WORDS)]),
        .rd_tag    (xl_ppn_w),
        .rd_tag_ok (xl_hit_w),
        .rd_hit    (ca_hit_w),
        .rd_data   (ca_word_w),
        .fill_en   (line_fill_en),
        .fill_set  (line_fill_set),
        .fill_tag  (line_fill_tag),
        .fill_line (line_fill_data)
    );

    always_comb begin
        resp_d = '0;
        if (rd_req) begin
            resp_d.xl_hit = xl_hit_w;
            resp_d.ca_hit = ca_hit_w;
            if (xl_hit_w) resp_d.pa   = {xl_ppn_w, rd_va[PAGE_BITS-1:0]};
            if (ca_hit_w) resp_d.data = ca_word_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign rd_pa     = resp_q.pa;
    assign rd_data   = resp_q.data;
    assign tlb_hit   = resp_q.xl_hit;
    assign cache_hit = resp_q.ca_hit;

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!tlb_hit && !cache_hit));

    assert_hit_needs_xlat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cache_hit |-> tlb_hit);

    assert_offset_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && xl_hit_w) |=> (rd_pa[PAGE_BITS-1:0] == $past(rd_va[PAGE_BITS-1:0])));

endmodule

// File: tb/sim_xlat_cache_lookup.sv
`timescale 1ns/1ps
module sim_xlat_cache_lookup;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         rd_req;
    logic [31:0]  rd_va;
    logic [31:0]  rd_pa;
    logic [31:0]  rd_data;
    logic         tlb_hit;
    logic         cache_hit;
    logic         tlb_fill_en;
    logic [17:0]  tlb_fill_vpn;
    logic [17:0]  tlb_fill_ppn;
    logic         line_fill_en;
    logic [17:0]  line_fill_tag;
    logic [8:0]   line_fill_set;
    logic [255:0] line_fill_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    xlat_cache_lookup u0 (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_va(rd_va),
        .rd_pa(rd_pa), .rd_data(rd_data), .tlb_hit(tlb_hit), .cache_hit(cache_hit),
        .tlb_fill_en(tlb_fill_en), .tlb_fill_vpn(tlb_fill_vpn), .tlb_fill_ppn(tlb_fill_ppn),
        .line_fill_en(line_fill_en), .line_fill_tag(line_fill_tag),
        .line_fill_set(line_fill_set), .line_fill_data(line_fill_data)
    );

    function automatic logic [31:0] word_of(input logic [17:0] ppn, input logic [8:0] set,
                                            input logic [2:0] w);
        return {ppn[13:0], set, w, 6'h2A};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tlb_fill(input logic [17:0] vpn, input logic [17:0] ppn);
        @(negedge clk);
        tlb_fill_en = 1'b1; tlb_fill_vpn = vpn; tlb_fill_ppn = ppn;
        @(negedge clk);
        tlb_fill_en = 1'b0;
    endtask

    task automatic line_fill(input logic [17:0] tag, input logic [8:0] set);
        logic [255:0] ln;
        for (int w = 0; w < 8; w++) ln[w*32 +: 32] = word_of(tag, set, 3'(w));
        @(negedge clk);
        line_fill_en = 1'b1; line_fill_tag = tag; line_fill_set = set; line_fill_data = ln;
        @(negedge clk);
        line_fill_en = 1'b0;
    endtask

    // Issue one read and check the registered result one edge later.
    task automatic rd_check(input string req, input logic [17:0] vpn, input logic [8:0] set,
                            input logic [2:0] w, input logic e_tlb, input logic e_ca,
                            input logic [17:0] e_ppn);
        @(negedge clk);
        rd_req = 1'b1; rd_va = {vpn, set, w, 2'b00};
        @(negedge clk);
        rd_req = 1'b0;
        chk({req, " tlb_hit"},   64'(tlb_hit),   64'(e_tlb));
        chk({req, " cache_hit"}, 64'(cache_hit), 64'(e_ca));
        chk({req, " pa"}, 64'(rd_pa), e_tlb ? 64'({e_ppn, set, w, 2'b00}) : 64'd0);
        if (e_ca) chk({req, " data"}, 64'(rd_data), 64'(word_of(e_ppn, set, w)));
    endtask

    // {vpn, set, word, exp_tlb, exp_cache, exp_ppn}
    localparam int NV = 8;
    localparam logic [49:0] VEC [NV] = '{
        {18'h00011, 9'd3,   3'd0, 1'b1, 1'b1, 18'h00A01},  // R2 R4 word 0
        {18'h00011, 9'd3,   3'd7, 1'b1, 1'b1, 18'h00A01},  // R4 last word
        {18'h3FFFF, 9'd3,   3'd5, 1'b1, 1'b1, 18'h00A01},  // R10 alias page
        {18'h00022, 9'd3,   3'd2, 1'b1, 1'b1, 18'h00B02},  // R6 second way
        {18'h00044, 9'd511, 3'd1, 1'b1, 1'b1, 18'h3FFFF},  // R4 top set
        {18'h00044, 9'd3,   3'd0, 1'b1, 1'b0, 18'h3FFFF},  // R4 tag mismatch
        {18'h00055, 9'd3,   3'd0, 1'b0, 1'b0, 18'h00000},  // R3 R5 no translation
        {18'h00011, 9'd4,   3'd0, 1'b1, 1'b0, 18'h00A01}   // R4 empty set
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rd_req = 1'b0; rd_va = '0;
        tlb_fill_en = 1'b0; tlb_fill_vpn = '0; tlb_fill_ppn = '0;
        line_fill_en = 1'b0; line_fill_tag = '0; line_fill_set = '0; line_fill_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 reset tlb_hit",   64'(tlb_hit),   64'd0);
        chk("R1 reset cache_hit", 64'(cache_hit), 64'd0);
        chk("R1 reset pa",        64'(rd_pa),     64'd0);
        rd_check("R1 empty tlb", 18'h00011, 9'd3, 3'd0, 1'b0, 1'b0, 18'h0);

        // R8 entries 0..3 in turn
        tlb_fill(18'h00011, 18'h00A01);
        tlb_fill(18'h00022, 18'h00B02);
        tlb_fill(18'h3FFFF, 18'h00A01);
        tlb_fill(18'h00044, 18'h3FFFF);
        rd_check("R1 empty cache", 18'h00011, 9'd3, 3'd0, 1'b1, 1'b0, 18'h00A01);

        line_fill(18'h00A01, 9'd3);    // R6 way 0
        line_fill(18'h00B02, 9'd3);    // R6 way 1
        line_fill(18'h3FFFF, 9'd511);

        for (int i = 0; i < NV; i++) begin
            rd_check($sformatf("R4 vec%0d", i), VEC[i][49:32], VEC[i][31:23], VEC[i][22:20],
                     VEC[i][19], VEC[i][18], VEC[i][17:0]);
        end

        // R9 a hit, then an idle cycle
        rd_check("R9 pre", 18'h00022, 9'd3, 3'd1, 1'b1, 1'b1, 18'h00B02);
        @(negedge clk);
        chk("R9 idle tlb_hit",   64'(tlb_hit),   64'd0);
        chk("R9 idle cache_hit", 64'(cache_hit), 64'd0);

        // R7 touch way 0 (A01), so way 1 (B02) is the victim
        rd_check("R7 touch", 18'h00011, 9'd3, 3'd3, 1'b1, 1'b1, 18'h00A01);
        line_fill(18'h00C03, 9'd3);
        rd_check("R7 victim gone", 18'h00022, 9'd3, 3'd0, 1'b1, 1'b0, 18'h00B02);
        rd_check("R7 recent kept", 18'h00011, 9'd3, 3'd6, 1'b1, 1'b1, 18'h00A01);

        // R8 fifth fill replaces entry 0 (vpn 0x11)
        tlb_fill(18'h00066, 18'h00C03);
        rd_check("R8 new entry", 18'h00066, 9'd3, 3'd4, 1'b1, 1'b1, 18'h00C03);
        rd_check("R8 entry0 gone", 18'h00011, 9'd3, 3'd0, 1'b0, 1'b0, 18'h0);
        rd_check("R10 alias kept", 18'h3FFFF, 9'd3, 3'd2, 1'b1, 1'b1, 18'h00A01);
        // R5 line for page 0xA01 present, but lookup page untranslated
        rd_check("R5 gated", 18'h00077, 9'd3, 3'd0, 1'b0, 1'b0, 18'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule